// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Delay Slots

This block produces the instruction fetch address for a 32-bit scalar core whose jumps and branches take effect one instruction late. It keeps three addresses: the fetch pointer (the next instruction to fetch), the address after that (the successor), and the address of the instruction whose decoded control signals are on the inputs this cycle. A control transfer changes the successor rather than the fetch pointer. The instruction already queued behind a jump therefore always runs, and the block flags that instruction as sitting in a delay slot.

The decoder supplies one transfer kind per executed instruction, with the jump immediate, the branch offset and a register target. An exception controller may redirect the sequence to a handler address. The block also holds one pending load result and presents it for write-back during the following instruction. That instruction still reads the old register contents. The sequencer advances only on cycles where `step` is high. A cycle in which `cur_valid` is low has no executing instruction, so its decode inputs are ignored.

Top module: `pcseq_top`

## Requirements
- R1: Synchronous active-high reset sets the fetch address to 0xBFC00000 and the successor (visible on `link_val`) to 0xBFC00004, and clears `cur_valid`, `in_delay_slot` and `wb_en`.
- R2: On a step with no transfer and no redirect, `cur_pc` takes the old fetch address, the fetch address takes the old successor, the successor becomes that value plus 4, and `cur_valid` becomes 1.
- R3: Transfer kinds 1 (J) and 2 (JAL) set the new fetch address to {successor[31:28], jump_imm, 2'b00}.
- R4: Kind 5 (taken branch) sets the new fetch address to successor + (sign-extended br_off << 2) - 4.
- R5: Kinds 3 (JR) and 4 (JALR) set the new fetch address to `reg_tgt`.
- R6: `link_val` always shows the current successor. `link_we` is high for an executed JAL with `link_idx` = 31, and for an executed JALR with a nonzero `link_rd`, with `link_idx` = `link_rd`.
- R7: `in_delay_slot` is 1 for the instruction stepped in right after an executed transfer (kinds 1 to 5), and 0 otherwise.
- R8: When `cur_valid` is 1 and `cur_pc[1:0]` is not zero, `addr_err` is 1. That instruction's transfer, link write and load are ignored, and the step proceeds as in R2.
- R9: A step with `exc_take` sets the fetch address to `exc_vec` and the successor to `exc_vec`+4, clears `cur_valid` and `in_delay_slot`, leaves `cur_pc` unchanged, and discards any transfer or load of that cycle.
- R10: A load (`ld_en`) on an executed step appears on `wb_en`/`wb_idx`/`wb_data` from the next cycle until the following step, which clears or replaces it.
- R11: A load whose destination index is 0 is discarded: `wb_en` stays 0.
- R12: With `step` low, every output that depends only on state keeps its value.
- R13: While `cur_valid` is 0, decode inputs have no effect: no link write, no transfer, no load capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance one instruction this cycle |
| xfer_kind | input | 3 | Transfer kind of current instruction (0 none, 1 J, 2 JAL, 3 JR, 4 JALR, 5 taken branch) |
| jump_imm | input | 26 | Absolute jump immediate |
| br_off | input | 16 | Branch word offset |
| reg_tgt | input | 32 | Register value for JR/JALR |
| link_rd | input | 5 | Link destination for JALR |
| exc_take | input | 1 | Exception redirect request |
| exc_vec | input | 32 | Handler address |
| ld_en | input | 1 | Current instruction produces a load result |
| ld_idx | input | 5 | Load destination register |
| ld_data | input | 32 | Loaded value |
| fetch_addr | output | 32 | Address to fetch next |
| cur_pc | output | 32 | Address of the executing instruction |
| cur_valid | output | 1 | An instruction is executing |
| in_delay_slot | output | 1 | Executing instruction sits in a delay slot |
| addr_err | output | 1 | Executing instruction address is misaligned |
| link_val | output | 32 | Return address (current successor) |
| link_we | output | 1 | Write link value this step |
| link_idx | output | 5 | Register receiving the link value |
| wb_en | output | 1 | Pending load write-back valid |
| wb_idx | output | 5 | Pending load destination |
| wb_data | output | 32 | Pending load value |

## Verification
The bench targets the ordering of control transfers. A jump must still let the queued instruction run. A design that updated the fetch pointer directly would skip that slot and report the wrong `cur_pc`. A branch with a negative offset and the -4 correction is checked, as is a JR to a misaligned target that later raises `addr_err` while a jump and a load arrive in the same cycle. An exception arriving in the same cycle as a taken branch is checked for priority and for the bubble that follows. Loads to register 0 and loads held across stalled cycles catch a slot that leaks or is dropped.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int IMMJ = 26;
    localparam int IMMB = 16;
    localparam int STEP_BYTES = XLEN / 8;
    localparam int ALIGN_BITS = $clog2(STEP_BYTES);
    localparam logic [XLEN-1:0] STEP_INC = XLEN'(STEP_BYTES);

    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_J    = 3'd1,
        XF_JAL  = 3'd2,
        XF_JR   = 3'd3,
        XF_JALR = 3'd4,
        XF_BR   = 3'd5
    } xfer_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] cur;
        logic            cv;
        logic            ds;
    } seq_state_t;

    typedef struct packed {
        logic            v;
        logic [RIDX-1:0] idx;
        logic [XLEN-1:0] data;
    } ld_slot_t;

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] npc,
                                                  input logic [IMMJ-1:0] imm);
        return {npc[XLEN-1:IMMJ+2], imm, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] npc,
                                                    input logic [IMMB-1:0] off);
        logic [XLEN-1:0] sx;
        sx = {{(XLEN-IMMB-2){off[IMMB-1]}}, off, 2'b00};
        return npc + sx - STEP_INC;
    endfunction
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0] npc,
    input  logic [2:0]      kind,
    input  logic [IMMJ-1:0] imm,
    input  logic [IMMB-1:0] off,
    input  logic [XLEN-1:0] rtgt,
    input  logic [RIDX-1:0] rd,
    input  logic            exec,
    output logic [XLEN-1:0] dest,
    output logic            taken,
    output logic            lwe,
    output logic [RIDX-1:0] lidx
);
    xfer_e k;
    assign k = xfer_e'(kind);

    always_comb begin
        dest  = npc;
        taken = 1'b0;
        lwe   = 1'b0;
        lidx  = RIDX'(LINK_REG);
        if (exec) begin
            case (k)
                XF_J: begin
                    dest  = jump_dest(npc, imm);
                    taken = 1'b1;
                end
                XF_JAL: begin
                    dest  = jump_dest(npc, imm);
                    taken = 1'b1;
                    lwe   = 1'b1;
                end
                XF_JR: begin
                    dest  = rtgt;
                    taken = 1'b1;
                end
                XF_JALR: begin
                    dest  = rtgt;
                    taken = 1'b1;
                    lwe   = (rd != '0);
                    lidx  = rd;
                end
                XF_BR: begin
                    dest  = branch_dest(npc, off);
                    taken = 1'b1;
                end
                default: begin
                    dest  = npc;
                    taken = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        if (!exec) assert (!taken && !lwe); // R13
    end
endmodule

// File: rtl/pcseq_ldslot.sv
module pcseq_ldslot
    import pcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            cap,
    input  logic [RIDX-1:0] idx,
    input  logic [XLEN-1:0] data,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data
);
    ld_slot_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (adv) begin
            slot.v    <= cap && (idx != '0);
            slot.idx  <= idx;
            slot.data <= data;
        end
    end

    assign wb_en   = slot.v;
    assign wb_idx  = slot.idx;
    assign wb_data = slot.data;

    AST_WB_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != '0)); // R11
    AST_SLOT_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (adv && !cap) |=> !wb_en); // R10
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(wb_en) && $stable(wb_idx) && $stable(wb_data))); // R12
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
    parameter int          LINK_REG  = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic [2:0]  xfer_kind,
    input  logic [25:0] jump_imm,
    input  logic [15:0] br_off,
    input  logic [31:0] reg_tgt,
    input  logic [4:0]  link_rd,
    input  logic        exc_take,
    input  logic [31:0] exc_vec,
    input  logic        ld_en,
    input  logic [4:0]  ld_idx,
    input  logic [31:0] ld_data,
    output logic [31:0] fetch_addr,
    output logic [31:0] cur_pc,
    output logic        cur_valid,
    output logic        in_delay_slot,
    output logic        addr_err,
    output logic [31:0] link_val,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic        wb_en,
    output logic [4:0]  wb_idx,
    output logic [31:0] wb_data
);
    seq_state_t      st;
    logic            exec;
    logic            taken;
    logic [XLEN-1:0] dest;
    logic            lwe_raw;

    assign addr_err = st.cv && (st.cur[ALIGN_BITS-1:0] != '0);
    assign exec     = st.cv && !addr_err;

    pcseq_target #(.LINK_REG(LINK_REG)) u_tgt (
        .npc   (st.npc),
        .kind  (xfer_kind),
        .imm   (jump_imm),
        .off   (br_off),
        .rtgt  (reg_tgt),
        .rd    (link_rd),
        .exec  (exec),
        .dest  (dest),
        .taken (taken),
        .lwe   (lwe_raw),
        .lidx  (link_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.pc  <= RESET_VEC;
            st.npc <= RESET_VEC + STEP_INC;
            st.cur <= '0;
            st.cv  <= 1'b0;
            st.ds  <= 1'b0;
        end else if (step) begin
            if (exc_take) begin
                st.pc <= exc_vec;
                st.npc <= exc_vec + STEP_INC;
                st.cv  <= 1'b0;
                st.ds  <= 1'b0;
            end else begin
                st.cur <= st.pc;
                st.pc  <= dest;
                st.npc <= dest + STEP_INC;
                st.cv  <= 1'b1;
                st.ds  <= taken;
            end
        end
    end

    pcseq_ldslot u_ld (
        .clk     (clk),
        .rst     (rst),
        .adv     (step),
        .cap     (exec && ld_en && !exc_take),
        .idx     (ld_idx),
        .data    (ld_data),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (wb_data)
    );

    assign fetch_addr    = st.pc;
    assign cur_pc        = st.cur;
    assign cur_valid     = st.cv;
    assign in_delay_slot = st.ds;
    assign link_val      = st.npc;
    assign link_we       = lwe_raw;

    AST_RESET_VEC: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr == RESET_VEC && link_val == RESET_VEC + STEP_INC && !cur_valid)); // R1
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && !exc_take) |=> (cur_pc == $past(fetch_addr) && cur_valid)); // R2
    AST_EXC_WINS: assert property (@(posedge clk) disable iff (rst)
        (step && exc_take) |=> (fetch_addr == $past(exc_vec) && link_val == $past(exc_vec) + STEP_INC
                                && !cur_valid && !in_delay_slot)); // R9
    AST_MISALIGN_SKIP: assert property (@(posedge clk) disable iff (rst)
        (step && !exc_take && addr_err) |=> (fetch_addr == $past(link_val) && !in_delay_slot)); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(fetch_addr) && $stable(cur_pc) && $stable(link_val) && $stable(in_delay_slot))); // R12
    AST_LINK_GATED: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (cur_valid && !addr_err)); // R6
endmodule

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [2:0]  xfer_kind = '0;
    logic [25:0] jump_imm = '0;
    logic [15:0] br_off = '0;
    logic [31:0] reg_tgt = '0;
    logic [4:0]  link_rd = '0;
    logic        exc_take = 1'b0;
    logic [31:0] exc_vec = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] fetch_addr, cur_pc, link_val, wb_data;
    logic        cur_valid, in_delay_slot, addr_err, link_we, wb_en;
    logic [4:0]  link_idx, wb_idx;

    pcseq_top u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench reference state
    logic [31:0] m_pc, m_npc, m_cur, s_data;
    logic        m_cv, m_ds, s_v;
    logic [4:0]  s_idx;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic m_exec();
        return m_cv && (m_cur[1:0] == 2'b00);
    endfunction

    task automatic cmp_state();
        chk("R2 fetch_addr", fetch_addr, m_pc);
        chk("R2 cur_pc", cur_pc, m_cur);
        chk("R9 cur_valid", 32'(cur_valid), 32'(m_cv));
        chk("R7 in_delay_slot", 32'(in_delay_slot), 32'(m_ds));
        chk("R6 link_val", link_val, m_npc);
        chk("R10 wb_en", 32'(wb_en), 32'(s_v));
        if (s_v) begin
            chk("R10 wb_idx", 32'(wb_idx), 32'(s_idx));
            chk("R10 wb_data", wb_data, s_data);
        end
    endtask

    task automatic cyc(input bit st, input logic [2:0] k, input logic [25:0] im,
                       input logic [15:0] of, input logic [31:0] rt, input logic [4:0] rd,
                       input bit ex, input logic [31:0] ev, input bit lv,
                       input logic [4:0] li, input logic [31:0] ld);
        logic [31:0] tgt;
        logic        tk, ew, lw;
        step = st; xfer_kind = k; jump_imm = im; br_off = of; reg_tgt = rt;
        link_rd = rd; exc_take = ex; exc_vec = ev; ld_en = lv; ld_idx = li; ld_data = ld;
        #1;
        ew = m_exec();
        lw = ew && (k == 3'd2 || (k == 3'd4 && rd != 0));
        chk("R8 addr_err", 32'(addr_err), 32'(m_cv && m_cur[1:0] != 0));
        chk("R6 link_we", 32'(link_we), 32'(lw));
        if (lw) chk("R6 link_idx", 32'(link_idx), (k == 3'd2) ? 32'd31 : 32'(rd));
        tgt = m_npc; tk = 1'b0;
        if (ew) begin
            case (k)
                3'd1, 3'd2: begin tgt = {m_npc[31:28], im, 2'b00}; tk = 1'b1; end
                3'd3, 3'd4: begin tgt = rt; tk = 1'b1; end
                3'd5: begin tgt = m_npc + {{14{of[15]}}, of, 2'b00} - 32'd4; tk = 1'b1; end
                default: ;
            endcase
        end
        @(posedge clk);
        if (st) begin
            if (ex) begin
                m_pc = ev; m_npc = ev + 32'd4; m_cv = 1'b0; m_ds = 1'b0; s_v = 1'b0;
            end else begin
                m_cur = m_pc; m_pc = tgt; m_npc = tgt + 32'd4; m_cv = 1'b1; m_ds = tk;
                s_v = ew && lv && (li != 0); s_idx = li; s_data = ld;
            end
        end
        @(negedge clk);
        cmp_state();
    endtask

    task automatic plain();
        cyc(1, 3'd0, '0, '0, '0, '0, 0, '0, 0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        m_pc = 32'hBFC0_0000; m_npc = 32'hBFC0_0004; m_cur = '0; m_cv = 0; m_ds = 0;
        s_v = 0; s_idx = '0; s_data = '0;
        seed = $urandom(32'd20240330);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 fetch_addr", fetch_addr, 32'hBFC0_0000);
        chk("R1 link_val", link_val, 32'hBFC0_0004);
        chk("R1 cur_valid", 32'(cur_valid), 32'd0);
        chk("R1 wb_en", 32'(wb_en), 32'd0);
        // R13 first cycle has no instruction: JAL ignored
        cyc(1, 3'd2, 26'h123, '0, '0, '0, 0, '0, 1, 5'd3, 32'h5);
        chk("R13 no transfer", fetch_addr, 32'hBFC0_0004);
        chk("R13 no load", 32'(wb_en), 32'd0);
        plain();
        chk("R2 directed cur", cur_pc, 32'hBFC0_0004);
        // R3 JAL at BFC00004, successor BFC0000C
        cyc(1, 3'd2, 26'h0000100, '0, '0, '0, 0, '0, 0, '0, '0);
        chk("R3 jump dest", fetch_addr, 32'hB000_0400);
        chk("R7 slot runs", cur_pc, 32'hBFC0_0008);
        chk("R7 flag", 32'(in_delay_slot), 32'd1);
        plain();
        chk("R7 flag clear", 32'(in_delay_slot), 32'd0);
        // R4 branch back by two words at B0000400, successor B0000408
        cyc(1, 3'd5, '0, 16'hFFFE, '0, '0, 0, '0, 0, '0, '0);
        chk("R4 branch dest", fetch_addr, 32'hB000_03FC);
        // R11 load into r0
        cyc(1, 3'd0, '0, '0, '0, '0, 0, '0, 1, 5'd0, 32'h1234);
        chk("R11 r0 dropped", 32'(wb_en), 32'd0);
        // R10 load delay
        cyc(1, 3'd0, '0, '0, '0, '0, 0, '0, 1, 5'd7, 32'hDEAD_BEEF);
        chk("R10 visible next", wb_data, 32'hDEAD_BEEF);
        // R12 stall holds
        cyc(0, 3'd1, 26'h3, '0, '0, '0, 0, '0, 1, 5'd9, 32'h9);
        cyc(0, 3'd0, '0, '0, '0, '0, 0, '0, 0, '0, '0);
        chk("R12 slot held", 32'(wb_idx), 32'd7);
        plain();
        chk("R10 retired", 32'(wb_en), 32'd0);
        // R5 JR to misaligned target, then R8
        cyc(1, 3'd4, '0, '0, 32'h0000_1002, 5'd0, 0, '0, 0, '0, '0);
        chk("R5 reg dest", fetch_addr, 32'h0000_1002);
        plain();
        cyc(1, 3'd1, 26'h44, '0, '0, '0, 0, '0, 1, 5'd4, 32'h44);
        chk("R8 transfer ignored", fetch_addr, 32'h0000_100A);
        chk("R8 load ignored", 32'(wb_en), 32'd0);
        // R9 exception beats a branch
        cyc(1, 3'd5, '0, 16'h0010, '0, '0, 1, 32'h8000_0080, 1, 5'd2, 32'h2);
        chk("R9 handler", fetch_addr, 32'h8000_0080);
        chk("R9 succ", link_val, 32'h8000_0084);
        plain();
        chk("R9 handler runs", cur_pc, 32'h8000_0080);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rt;
            rt = {$urandom, 2'b00} >> 2;
            rt = {rt[31:2], (($urandom % 8) == 0) ? 2'($urandom) : 2'b00};
            cyc(($urandom % 8) != 0, 3'($urandom % 7), 26'($urandom), 16'($urandom), rt,
                5'($urandom), ($urandom % 16) == 0, {$urandom} & 32'hFFFF_FFFC,
                ($urandom % 3) == 0, 5'($urandom % 4), $urandom);
        end
        finish_run();
    end
endmodule